// File: doc/BRIEF.md
# Two-Pipe Layer Priority Compositor

This block builds one output pixel per clock from four rectangular layers. The pixel source has already fetched the layer data and converted it to ARGB. Each layer has an enable, a signed origin, an unsigned extent, a pipe select, a 2-bit priority and an optional 8-bit global alpha. The block receives the current screen coordinate and one ARGB sample per layer, and it returns an RGB colour two clocks later.

Composition takes two steps. First, each of the two pipes selects a single covering layer by priority, and no blending happens inside a pipe. Second, the pipe-1 winner is alpha-blended over the pipe-0 winner, or over the background colour where pipe 0 is empty. A build-time option reproduces a known hardware flaw: a pipe-0 winner at priority 0 that is not fully opaque shows the background colour in place of its own pixel. Coordinates outside the programmed display size are blanked.

Top module: `lyr_duo_compositor`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_rgb` is 0.
- R2: The colour for a coordinate and configuration presented before clock edge k appears on `out_rgb` after edge k+1. This is a latency of two registers.
- R3: Layer i covers pixel (px,py) when ox <= px < ox+w and oy <= py < oy+h. The origin is signed, using `CW` bits at slice i of `lay_x`/`lay_y`, and the extent comes from `lay_w`/`lay_h`. A layer may therefore extend past the left or top edge, and a zero extent covers nothing.
- R4: A layer whose `lay_en` bit is 0 covers no pixel.
- R5: Inside a pipe, the covering layer with the numerically largest `lay_prio` field supplies the pipe's colour unchanged. `lay_pipe` bit i = 0 puts layer i in pipe 0 and 1 puts it in pipe 1. The alpha of the pipe-0 winner is never applied.
- R6: When two covering layers in the same pipe have equal priority, the layer with the lower index wins.
- R7: For each 8-bit channel, out = round((a*F + (255-a)*B)/255). F is the pipe-1 colour and a is its alpha. B is the pipe-0 colour, or `bg_rgb` when pipe 0 is empty. With no pipe-1 layer, out = B. The result is exact at a = 0 and a = 255.
- R8: A layer's alpha is `lay_galpha` slice i when `lay_ga_en` bit i is 1. Otherwise it is bits [31:24] of that layer's `lay_argb` slice, whose bits [23:0] are R,G,B from high to low.
- R9: Where no enabled layer covers an on-screen pixel, `out_rgb` equals `bg_rgb`.
- R10: A coordinate with px >= `disp_w` or py >= `disp_h` produces `out_rgb` = 0.
- R11: With `LOW_ALPHA_QUIRK` = 1, a pipe-0 winner that has priority 0 and alpha below 255 contributes `bg_rgb` as the pipe-0 colour. With the parameter at 0, no such substitution occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_x | input | CW-1 | Current screen column |
| pos_y | input | CW-1 | Current screen row |
| disp_w | input | CW-1 | Active display width |
| disp_h | input | CW-1 | Active display height |
| bg_rgb | input | 24 | Background colour |
| lay_en | input | NLAY | Per-layer enable |
| lay_pipe | input | NLAY | Per-layer pipe select |
| lay_prio | input | NLAY*PRW | Per-layer priority |
| lay_ga_en | input | NLAY | Per-layer global-alpha enable |
| lay_galpha | input | NLAY*8 | Per-layer global alpha |
| lay_x | input | NLAY*CW | Signed layer origin, column |
| lay_y | input | NLAY*CW | Signed layer origin, row |
| lay_w | input | NLAY*(CW-1) | Layer width |
| lay_h | input | NLAY*(CW-1) | Layer height |
| lay_argb | input | NLAY*32 | Current ARGB sample of each layer |
| out_rgb | output | 24 | Composited colour |

## Verification
The priority pick inside pipe 0 and the flaw substitution can act on the same pixel. When they do, the substitution must follow whichever layer actually won, not the priority-0 layer alone. The bench provokes this in two ways. It overlaps a non-opaque priority-0 layer with a higher-priority layer in pipe 0, and it shows that same priority-0 layer alone. It drives two instances, one with the flaw option and one without, from the same inputs and compares each against hand-computed colours. The blend over a pipe-0 layer, as opposed to over the background, is judged in the same cycle as a global-alpha override.

// File: rtl/lyrc_pkg.sv
package lyrc_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;
  localparam int PIX_W = 4 * CH_W;

  // rounded division by 255 of a weighted channel sum (at most 255*255)
  function automatic logic [CH_W-1:0] div255_rnd(input logic [15:0] v);
    logic [16:0] t;
    t = {1'b0, v} + 17'd128;
    return CH_W'((t + (t >> 8)) >> 8);
  endfunction
endpackage

// File: rtl/lyrc_cover.sv
module lyrc_cover #(
  parameter int CW = 12
) (
  input  logic [CW-2:0]        pos_x,
  input  logic [CW-2:0]        pos_y,
  input  logic                 en,
  input  logic [CW-1:0]        org_x,
  input  logic [CW-1:0]        org_y,
  input  logic [CW-2:0]        ext_w,
  input  logic [CW-2:0]        ext_h,
  input  logic [7:0]           pix_a,
  input  logic                 ga_en,
  input  logic [7:0]           galpha,
  output logic                 hit,
  output logic [7:0]           eff_a
);
  logic signed [CW:0] px_s, py_s, ox_s, oy_s, ex_s, ey_s;
  logic               in_x, in_y;

  always_comb begin
    px_s = signed'({2'b00, pos_x});
    py_s = signed'({2'b00, pos_y});
    ox_s = signed'({org_x[CW-1], org_x});
    oy_s = signed'({org_y[CW-1], org_y});
    ex_s = ox_s + signed'({2'b00, ext_w});
    ey_s = oy_s + signed'({2'b00, ext_h});
    in_x = (ox_s <= px_s) && (px_s < ex_s);
    in_y = (oy_s <= py_s) && (py_s < ey_s);
    hit  = en && in_x && in_y;
    eff_a = ga_en ? galpha : pix_a;
  end
endmodule

// File: rtl/lyrc_pick.sv
module lyrc_pick
  import lyrc_pkg::*;
#(
  parameter int NLAY     = 4,
  parameter int PRW      = 2,
  parameter bit PIPE_SEL = 1'b0,
  parameter bit QUIRK_EN = 1'b0
) (
  input  logic [NLAY-1:0]       cand_hit,
  input  logic [NLAY-1:0]       lay_pipe,
  input  logic [NLAY*PRW-1:0]   lay_prio,
  input  logic [NLAY*CH_W-1:0]  eff_a,
  input  logic [NLAY*RGB_W-1:0] lay_rgb,
  input  logic [RGB_W-1:0]      bg_rgb,
  output logic                  hit_o,
  output logic [CH_W-1:0]       a_o,
  output logic [RGB_W-1:0]      rgb_o
);
  logic              found;
  logic [PRW-1:0]    best_p;
  logic [CH_W-1:0]   best_a;
  logic [RGB_W-1:0]  best_rgb;
  logic              quirk_hit;

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    best_p   = '0;
    best_a   = '0;
    best_rgb = '0;
    for (int i = 0; i < NLAY; i++) begin
      if (cand_hit[i] && (lay_pipe[i] == PIPE_SEL) &&
          (!found || (lay_prio[i*PRW +: PRW] > best_p))) begin
        found    = 1'b1;
        best_p   = lay_prio[i*PRW +: PRW];
        best_a   = eff_a[i*CH_W +: CH_W];
        best_rgb = lay_rgb[i*RGB_W +: RGB_W];
      end
    end
  end

  always_comb begin
    quirk_hit = QUIRK_EN && found && (best_p == '0) && (best_a != 8'hFF);
    hit_o     = found;
    a_o       = best_a;
    rgb_o     = quirk_hit ? bg_rgb : best_rgb;
  end
endmodule

// File: rtl/lyrc_mix.sv
module lyrc_mix
  import lyrc_pkg::*;
(
  input  logic [CH_W-1:0] a,
  input  logic [CH_W-1:0] fg,
  input  logic [CH_W-1:0] bk,
  output logic [CH_W-1:0] mix
);
  logic [15:0] wsum;

  always_comb begin
    wsum = 16'(a) * 16'(fg) + 16'(8'hFF - a) * 16'(bk);
    mix  = div255_rnd(wsum);
  end
endmodule

// File: rtl/lyr_duo_compositor.sv
module lyr_duo_compositor
  import lyrc_pkg::*;
#(
  parameter int NLAY            = 4,
  parameter int CW              = 12,
  parameter int PRW             = 2,
  parameter bit LOW_ALPHA_QUIRK = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-2:0]          pos_x,
  input  logic [CW-2:0]          pos_y,
  input  logic [CW-2:0]          disp_w,
  input  logic [CW-2:0]          disp_h,
  input  logic [23:0]            bg_rgb,
  input  logic [NLAY-1:0]        lay_en,
  input  logic [NLAY-1:0]        lay_pipe,
  input  logic [NLAY*PRW-1:0]    lay_prio,
  input  logic [NLAY-1:0]        lay_ga_en,
  input  logic [NLAY*8-1:0]      lay_galpha,
  input  logic [NLAY*CW-1:0]     lay_x,
  input  logic [NLAY*CW-1:0]     lay_y,
  input  logic [NLAY*(CW-1)-1:0] lay_w,
  input  logic [NLAY*(CW-1)-1:0] lay_h,
  input  logic [NLAY*32-1:0]     lay_argb,
  output logic [23:0]            out_rgb
);
  localparam int PW = CW - 1;
  localparam int NPIPE = 2;

  logic [NLAY-1:0]       cov_vec;
  logic [NLAY*CH_W-1:0]  eff_a_flat;
  logic [NLAY*RGB_W-1:0] rgb_flat;

  // per-layer coverage and effective alpha
  for (genvar i = 0; i < NLAY; i++) begin : g_lay
    assign rgb_flat[i*RGB_W +: RGB_W] = lay_argb[i*PIX_W +: RGB_W];
    lyrc_cover #(.CW(CW)) u_cov (
      .pos_x  (pos_x),
      .pos_y  (pos_y),
      .en     (lay_en[i]),
      .org_x  (lay_x[i*CW +: CW]),
      .org_y  (lay_y[i*CW +: CW]),
      .ext_w  (lay_w[i*PW +: PW]),
      .ext_h  (lay_h[i*PW +: PW]),
      .pix_a  (lay_argb[i*PIX_W + RGB_W +: CH_W]),
      .ga_en  (lay_ga_en[i]),
      .galpha (lay_galpha[i*CH_W +: CH_W]),
      .hit    (cov_vec[i]),
      .eff_a  (eff_a_flat[i*CH_W +: CH_W])
    );
  end

  // stage one: priority pick per pipe
  logic             pk_hit [NPIPE];
  logic [CH_W-1:0]  pk_a   [NPIPE];
  logic [RGB_W-1:0] pk_rgb [NPIPE];

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    lyrc_pick #(
      .NLAY     (NLAY),
      .PRW      (PRW),
      .PIPE_SEL (p[0]),
      .QUIRK_EN ((p == 0) ? LOW_ALPHA_QUIRK : 1'b0)
    ) u_pick (
      .cand_hit (cov_vec),
      .lay_pipe (lay_pipe),
      .lay_prio (lay_prio),
      .eff_a    (eff_a_flat),
      .lay_rgb  (rgb_flat),
      .bg_rgb   (bg_rgb),
      .hit_o    (pk_hit[p]),
      .a_o      (pk_a[p]),
      .rgb_o    (pk_rgb[p])
    );
  end

  // stage-one register: blend operands
  logic [RGB_W-1:0] s1_base_q, s1_base_d;
  logic [RGB_W-1:0] s1_fg_q,   s1_fg_d;
  logic [CH_W-1:0]  s1_a_q,    s1_a_d;
  logic             s1_disp_q, s1_disp_d;

  always_comb begin
    s1_base_d = pk_hit[0] ? pk_rgb[0] : bg_rgb;
    s1_fg_d   = pk_rgb[1];
    s1_a_d    = pk_hit[1] ? pk_a[1] : '0;
    s1_disp_d = (pos_x < disp_w) && (pos_y < disp_h);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_base_q <= '0;
      s1_fg_q   <= '0;
      s1_a_q    <= '0;
      s1_disp_q <= 1'b0;
    end else begin
      s1_base_q <= s1_base_d;
      s1_fg_q   <= s1_fg_d;
      s1_a_q    <= s1_a_d;
      s1_disp_q <= s1_disp_d;
    end
  end

  // stage two: blend pipe 1 over base, per channel
  logic [RGB_W-1:0] mix_rgb;
  for (genvar c = 0; c < 3; c++) begin : g_ch
    lyrc_mix u_mix (
      .a   (s1_a_q),
      .fg  (s1_fg_q[c*CH_W +: CH_W]),
      .bk  (s1_base_q[c*CH_W +: CH_W]),
      .mix (mix_rgb[c*CH_W +: CH_W])
    );
  end

  logic [RGB_W-1:0] out_d;
  always_comb out_d = s1_disp_q ? mix_rgb : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_rgb <= '0;
    else        out_rgb <= out_d;
  end
endmodule

// File: rtl/lyrc_chk.sv
module lyrc_chk #(
  parameter int NLAY = 4,
  parameter int CW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW-2:0]   pos_x,
  input logic [CW-2:0]   pos_y,
  input logic [CW-2:0]   disp_w,
  input logic [CW-2:0]   disp_h,
  input logic [23:0]     bg_rgb,
  input logic [NLAY-1:0] lay_en,
  input logic [NLAY-1:0] lay_pipe,
  input logic [NLAY-1:0] cov_vec,
  input logic            p0_hit,
  input logic [23:0]     out_rgb
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_rgb == '0));

  // R4
  dis_nocover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cov_vec & ~lay_en) == 0);

  // R5
  pick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_hit |-> ((cov_vec & ~lay_pipe) != '0));

  // R9
  bg_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lay_en == '0) && (pos_x < disp_w) && (pos_y < disp_h))
      |=> ##1 (out_rgb == $past(bg_rgb, 2)));

  // R10
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_x >= disp_w) || (pos_y >= disp_h)) |=> ##1 (out_rgb == '0));
endmodule

bind lyr_duo_compositor lyrc_chk #(.NLAY(NLAY), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pos_x   (pos_x),
  .pos_y   (pos_y),
  .disp_w  (disp_w),
  .disp_h  (disp_h),
  .bg_rgb  (bg_rgb),
  .lay_en  (lay_en),
  .lay_pipe(lay_pipe),
  .cov_vec (cov_vec),
  .p0_hit  (pk_hit[0]),
  .out_rgb (out_rgb)
);

// File: tb/sim_lyr_duo_compositor.sv
`timescale 1ns/1ps
module sim_lyr_duo_compositor;
  localparam int NLAY = 4;
  localparam int CW   = 12;
  localparam int PRW  = 2;
  localparam int PW   = CW - 1;

  logic                 clk;
  logic                 rst_n;
  logic [PW-1:0]        pos_x, pos_y, disp_w, disp_h;
  logic [23:0]          bg_rgb;
  logic [NLAY-1:0]      lay_en, lay_pipe, lay_ga_en;
  logic [NLAY*PRW-1:0]  lay_prio;
  logic [NLAY*8-1:0]    lay_galpha;
  logic [NLAY*CW-1:0]   lay_x, lay_y;
  logic [NLAY*PW-1:0]   lay_w, lay_h;
  logic [NLAY*32-1:0]   lay_argb;
  logic [23:0]          out0, out1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  lyr_duo_compositor #(.NLAY(NLAY), .CW(CW), .PRW(PRW), .LOW_ALPHA_QUIRK(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
    .disp_w(disp_w), .disp_h(disp_h), .bg_rgb(bg_rgb),
    .lay_en(lay_en), .lay_pipe(lay_pipe), .lay_prio(lay_prio),
    .lay_ga_en(lay_ga_en), .lay_galpha(lay_galpha),
    .lay_x(lay_x), .lay_y(lay_y), .lay_w(lay_w), .lay_h(lay_h),
    .lay_argb(lay_argb), .out_rgb(out0));

  lyr_duo_compositor #(.NLAY(NLAY), .CW(CW), .PRW(PRW), .LOW_ALPHA_QUIRK(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
    .disp_w(disp_w), .disp_h(disp_h), .bg_rgb(bg_rgb),
    .lay_en(lay_en), .lay_pipe(lay_pipe), .lay_prio(lay_prio),
    .lay_ga_en(lay_ga_en), .lay_galpha(lay_galpha),
    .lay_x(lay_x), .lay_y(lay_y), .lay_w(lay_w), .lay_h(lay_h),
    .lay_argb(lay_argb), .out_rgb(out1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [10:0] x;
    logic [10:0] y;
    logic [23:0] rgb;
  } tv_t;

  localparam int NTV = 13;
  localparam tv_t TV [NTV] = '{
    '{11'd5,   11'd5,  24'hAA0000},  // R3 inside L0
    '{11'd0,   11'd0,  24'hAA0000},  // R3 first covered pixel
    '{11'd25,  11'd25, 24'h00BB00},  // R5 L1 beats L0 in pipe 0
    '{11'd35,  11'd35, 24'hFFFFFF},  // R8 global alpha overrides zero pixel alpha
    '{11'd49,  11'd49, 24'hFFFFFF},  // R3 last pixel of L3
    '{11'd50,  11'd50, 24'h00BB00},  // R3 just past L3
    '{11'd70,  11'd10, 24'h102030},  // R9 uncovered
    '{11'd40,  11'd10, 24'h102030},  // R3 just past L0
    '{11'd5,   11'd55, 24'h081098},  // R7 half alpha over background
    '{11'd19,  11'd69, 24'h081098},  // R3 corner of negative-origin L2
    '{11'd20,  11'd55, 24'h00BB00},  // R3 just past L2
    '{11'd100, 11'd10, 24'h000000},  // R10 column off screen
    '{11'd10,  11'd80, 24'h000000}   // R10 row off screen
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic set_lay(input int i, input logic en, input logic pipe,
                         input logic [1:0] pr, input logic gae, input logic [7:0] ga,
                         input int x, input int y, input int w, input int h,
                         input logic [31:0] argb);
    lay_en[i]              = en;
    lay_pipe[i]            = pipe;
    lay_prio[i*PRW +: PRW] = pr;
    lay_ga_en[i]           = gae;
    lay_galpha[i*8 +: 8]   = ga;
    lay_x[i*CW +: CW]      = CW'(x);
    lay_y[i*CW +: CW]      = CW'(y);
    lay_w[i*PW +: PW]      = PW'(w);
    lay_h[i*PW +: PW]      = PW'(h);
    lay_argb[i*32 +: 32]   = argb;
  endtask

  // present a pixel at a falling edge, let two rising edges pass, sample at the next falling edge
  task automatic put_px(input int x, input int y);
    @(negedge clk);
    pos_x = PW'(x);
    pos_y = PW'(y);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    pos_x = '0; pos_y = '0;
    disp_w = 11'd100; disp_h = 11'd80;
    bg_rgb = 24'h102030;
    lay_en = '0; lay_pipe = '0; lay_ga_en = '0; lay_prio = '0;
    lay_galpha = '0; lay_x = '0; lay_y = '0; lay_w = '0; lay_h = '0;
    lay_argb = '0;

    repeat (3) @(negedge clk);
    chk("R1 during reset", out0, 24'h000000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 first cycle after release", out0, 24'h000000);

    set_lay(0, 1, 0, 2'd0, 0, 8'h00,   0,  0, 40, 40, 32'hFFAA0000);
    set_lay(1, 1, 0, 2'd2, 0, 8'h00,  20, 20, 40, 40, 32'hFF00BB00);
    set_lay(2, 1, 1, 2'd1, 0, 8'h00, -10, 50, 30, 20, 32'h800000FF);
    set_lay(3, 1, 1, 2'd3, 1, 8'hFF,  30, 30, 20, 20, 32'h00FFFFFF);

    for (int k = 0; k < NTV; k++) begin
      put_px(int'(TV[k].x), int'(TV[k].y));
      chk($sformatf("table %0d (R3 R5 R7 R8 R9 R10)", k), out0, TV[k].rgb);
      chk($sformatf("table %0d quirk instance R11", k), out1, TV[k].rgb);
    end

    // R2: two-register latency
    put_px(70, 10);
    chk("R2 settled", out0, 24'h102030);
    pos_x = 11'd5; pos_y = 11'd5;
    @(posedge clk); @(negedge clk);
    chk("R2 one edge: old value", out0, 24'h102030);
    @(posedge clk); @(negedge clk);
    chk("R2 two edges: new value", out0, 24'hAA0000);

    // R6: equal priority in pipe 1, lower index wins
    set_lay(3, 1, 1, 2'd1, 1, 8'hFF, 0, 50, 10, 10, 32'h00FFFFFF);
    put_px(5, 55);
    chk("R6 tie keeps L2", out0, 24'h081098);
    set_lay(3, 1, 1, 2'd2, 1, 8'hFF, 0, 50, 10, 10, 32'h00FFFFFF);
    put_px(5, 55);
    chk("R5 higher priority L3 in pipe 1", out0, 24'hFFFFFF);

    // R4: disabled layers
    lay_en[3] = 1'b0;
    put_px(5, 55);
    chk("R4 disabled L3 ignored", out0, 24'h081098);
    lay_en[0] = 1'b0;
    put_px(5, 5);
    chk("R4 disabled L0 shows background", out0, 24'h102030);
    lay_en[0] = 1'b1;

    // R3: zero width covers nothing
    set_lay(1, 1, 0, 2'd2, 0, 8'h00, 20, 20, 0, 40, 32'hFF00BB00);
    put_px(25, 25);
    chk("R3 zero width", out0, 24'hAA0000);
    set_lay(1, 1, 0, 2'd2, 0, 8'h00, 20, 20, 40, 40, 32'hFF00BB00);

    // R7 / R8: blend over a pipe-0 layer
    set_lay(2, 1, 1, 2'd1, 1, 8'h40, 0, 0, 10, 10, 32'hFF0000FF);
    put_px(5, 5);
    chk("R7 quarter alpha over L0", out0, 24'h7F0040);
    set_lay(2, 1, 1, 2'd1, 1, 8'h00, 0, 0, 10, 10, 32'hFF0000FF);
    put_px(5, 5);
    chk("R7 zero alpha exact", out0, 24'hAA0000);
    set_lay(2, 1, 1, 2'd1, 0, 8'h00, 0, 0, 10, 10, 32'hFF0000FF);
    put_px(5, 5);
    chk("R8 pixel alpha opaque", out0, 24'h0000FF);

    // R11: low-alpha flaw on the pipe-0 priority-0 layer
    lay_en[2] = 1'b0;
    set_lay(0, 1, 0, 2'd0, 1, 8'hFE, 0, 0, 40, 40, 32'hFFAA0000);
    put_px(5, 5);
    chk("R5 pipe-0 alpha not applied", out0, 24'hAA0000);
    chk("R11 quirk shows background", out1, 24'h102030);
    put_px(25, 25);
    chk("R11 quirk skipped when L1 wins", out1, 24'h00BB00);
    set_lay(0, 1, 0, 2'd0, 0, 8'hFE, 0, 0, 40, 40, 32'hFFAA0000);
    put_px(5, 5);
    chk("R11 opaque pixel alpha no quirk", out1, 24'hAA0000);

    // R9 with every layer off and a new background
    lay_en = '0;
    bg_rgb = 24'h405060;
    put_px(5, 5);
    chk("R9 all layers off", out0, 24'h405060);

    finish_run();
  end
endmodule